// File: doc/BRIEF.md
# Register-Mapped GPIO with Flash Strobes and Serial Sensor Lines

This block is a 32-bit register-mapped GPIO with two ports, A and D. Each port has three registers: an output latch, an input view and an output-enable mask. A simple bus reaches the registers with a byte address, a write strobe and a read strobe. The block ignores the two low address bits and uses the rest as a word index. The window is 0x5C bytes wide, which gives 23 words. Every word index that is not part of a port is a plain scratch register.

Three bits of the port A output latch drive the control strobes of a NAND flash. A port A input read also reports the flash ready/busy line. Software drives a serial sensor through port D by bit-banging. When a port D output write changes the clock bit, the block sends a clock edge and a data bit to the sensor. The sensor's serial output appears in port D input reads.

Top module: `gpio_flash_sens`

## Requirements
- R1: After reset, every stored word is zero. `rdata_o`, the flash strobes, `sens_clk_o`, `sens_dat_o` and `sens_edge_o` are all zero.
- R2: A read returns its data on `rdata_o` in the cycle after the read strobe is sampled. `rdata_o` holds its value in every cycle that has no read strobe.
- R3: The plain word indices 0, 2, 3 to 16, and 18 to 22 read back the last value written to them.
- R4: A read of word index 1 (port A input) returns word 0 AND word 2, with `nand_rdy_i` ORed into bit 7.
- R5: A read of word index 17 (port D input) returns word 16 AND word 18, with `sens_so_i` ORed into bit 4.
- R6: Writes to word indices 1 and 17 have no effect. The readback of those indices does not change, and neither does any stored word.
- R7: One cycle after a write to word 0, `nand_ale_o` equals bit 6 of the written value, `nand_cle_o` equals bit 5 and `nand_ce_o` equals bit 4.
- R8: A write to word 16 whose bit 1 differs from the stored bit 1 raises `sens_edge_o` for one cycle after the write. In that cycle `sens_clk_o` takes the new bit 1 and `sens_dat_o` takes bit 4 of the written value.
- R9: A write to word 16 that leaves bit 1 unchanged does not pulse `sens_edge_o`. `sens_clk_o` and `sens_dat_o` keep their values.
- R10: Word indices 23 and above lie outside the window. Writes to them are ignored and reads of them return zero.
- R11: When a read and a write hit the same word in one cycle, the read returns the value the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 7 | Byte address; bits 6:2 form the word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| nand_rdy_i | input | 1 | Flash ready/busy line |
| nand_ale_o | output | 1 | Flash address latch enable |
| nand_cle_o | output | 1 | Flash command latch enable |
| nand_ce_o | output | 1 | Flash chip enable |
| sens_so_i | input | 1 | Serial output of the sensor |
| sens_clk_o | output | 1 | Serial clock level toward the sensor |
| sens_dat_o | output | 1 | Serial data bit toward the sensor |
| sens_edge_o | output | 1 | One-cycle pulse on each sensor clock edge |

## Verification
The hardest situation to reach is a port D output write that changes other bits but leaves the clock bit alone. It must not produce an edge, and it must not disturb the data bit that the last real edge latched. The stimulus first sends a rising edge with the data bit set. It then writes a value that keeps bit 1 high and clears bit 4, and checks that the pulse stays low and that the data line still holds 1. A falling edge then confirms that the edge logic still fires afterwards. A second hard case is a read and a write to the same word in one cycle. The bench drives both strobes on the same edge to show that the read returns the value from before the write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned WIN_BYTES    = 32'h5C;
  localparam int unsigned IDX_PA_DOUT  = 0;
  localparam int unsigned IDX_PA_DIN   = 1;
  localparam int unsigned IDX_PA_OE    = 2;
  localparam int unsigned IDX_PD_DOUT  = 16;
  localparam int unsigned IDX_PD_DIN   = 17;
  localparam int unsigned IDX_PD_OE    = 18;
  localparam int unsigned NAND_RDY_POS = 7;
  localparam int unsigned NAND_ALE_POS = 6;
  localparam int unsigned NAND_CLE_POS = 5;
  localparam int unsigned NAND_CE_POS  = 4;
  localparam int unsigned SENS_CLK_POS = 1;
  localparam int unsigned SENS_DAT_POS = 4;
  localparam int unsigned SENS_SO_POS  = 4;

  function automatic logic is_din(int unsigned idx);
    return (idx == IDX_PA_DIN) || (idx == IDX_PD_DIN);
  endfunction
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 23,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             widx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [WORDS-1:0][DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    if (is_din(g)) begin : g_view
      // input views hold no storage
      assign regs_o[g] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && (widx_i == IDX_W'(g))) q <= wdata_i;
      end
      assign regs_o[g] = q;
    end
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 23,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         re_i,
  input  logic [IDX_W-1:0]             ridx_i,
  input  logic [WORDS-1:0][DATA_W-1:0] regs_i,
  input  logic                         nand_rdy_i,
  input  logic                         sens_so_i,
  output logic [DATA_W-1:0]            rdata_o
);
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (ridx_i == IDX_W'(k)) rd_val = regs_i[k];
    end
    if (ridx_i == IDX_W'(IDX_PA_DIN)) begin
      rd_val = regs_i[IDX_PA_DOUT] & regs_i[IDX_PA_OE];
      rd_val[NAND_RDY_POS] = rd_val[NAND_RDY_POS] | nand_rdy_i;
    end else if (ridx_i == IDX_W'(IDX_PD_DIN)) begin
      rd_val = regs_i[IDX_PD_DOUT] & regs_i[IDX_PD_OE];
      rd_val[SENS_SO_POS] = rd_val[SENS_SO_POS] | sens_so_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) rdata_o <= rd_val;
  end

  AST_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (32'(ridx_i) >= WORDS)) |=> (rdata_o == '0)); // R10
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R2
endmodule

// File: rtl/gpio_nand_decode.sv
module gpio_nand_decode
  import gpio_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] pa_dout_i,
  output logic              ale_o,
  output logic              cle_o,
  output logic              ce_o
);
  assign ale_o = pa_dout_i[NAND_ALE_POS];
  assign cle_o = pa_dout_i[NAND_CLE_POS];
  assign ce_o  = pa_dout_i[NAND_CE_POS];
endmodule

// File: rtl/gpio_sens_if.sv
module gpio_sens_if
  import gpio_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_dout_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cur_clk_i,
  output logic              edge_o,
  output logic              clk_o,
  output logic              dat_o
);
  logic toggle;
  assign toggle = we_dout_i && (wdata_i[SENS_CLK_POS] != cur_clk_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_o <= 1'b0;
      clk_o  <= 1'b0;
      dat_o  <= 1'b0;
    end else begin
      edge_o <= toggle;
      if (toggle) begin
        clk_o <= wdata_i[SENS_CLK_POS];
        dat_o <= wdata_i[SENS_DAT_POS];
      end
    end
  end

  AST_EDGE_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> (clk_o != $past(clk_o))); // R8
  AST_QUIET_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_o |-> ($stable(clk_o) && $stable(dat_o))); // R9
endmodule

// File: rtl/gpio_flash_sens.sv
module gpio_flash_sens
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              nand_rdy_i,
  output logic              nand_ale_o,
  output logic              nand_cle_o,
  output logic              nand_ce_o,
  input  logic              sens_so_i,
  output logic              sens_clk_o,
  output logic              sens_dat_o,
  output logic              sens_edge_o
);
  localparam int unsigned WORDS = WIN_BYTES / 4;
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]             widx;
  logic [WORDS-1:0][DATA_W-1:0] regs;
  logic                         we_pd_dout;

  assign widx       = addr_i[ADDR_W-1:2];
  assign we_pd_dout = wr_en_i && (widx == IDX_W'(IDX_PD_DOUT));

  gpio_regfile #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .widx_i  (widx),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  gpio_rd_mux #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .re_i       (rd_en_i),
    .ridx_i     (widx),
    .regs_i     (regs),
    .nand_rdy_i (nand_rdy_i),
    .sens_so_i  (sens_so_i),
    .rdata_o    (rdata_o)
  );

  gpio_nand_decode #(.DATA_W(DATA_W)) u_nand (
    .pa_dout_i (regs[IDX_PA_DOUT]),
    .ale_o     (nand_ale_o),
    .cle_o     (nand_cle_o),
    .ce_o      (nand_ce_o)
  );

  gpio_sens_if #(.DATA_W(DATA_W)) u_sens (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_dout_i (we_pd_dout),
    .wdata_i   (wdata_i),
    .cur_clk_i (regs[IDX_PD_DOUT][SENS_CLK_POS]),
    .edge_o    (sens_edge_o),
    .clk_o     (sens_clk_o),
    .dat_o     (sens_dat_o)
  );

  AST_NAND_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && widx == IDX_W'(IDX_PA_DOUT)) |=>
      (nand_ale_o == $past(wdata_i[NAND_ALE_POS]) &&
       nand_cle_o == $past(wdata_i[NAND_CLE_POS]) &&
       nand_ce_o  == $past(wdata_i[NAND_CE_POS]))); // R7
  AST_DIN_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && widx == IDX_W'(IDX_PD_DIN)) |=>
      ($stable(regs[IDX_PD_DOUT]) && $stable(regs[IDX_PD_OE]))); // R6
endmodule

// File: tb/sim_gpio_flash_sens.sv
module sim_gpio_flash_sens;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nand_rdy = 1'b0, sens_so = 1'b0;
  logic        ale, cle, ce, s_clk, s_dat, s_edge;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpio_flash_sens u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .nand_rdy_i(nand_rdy), .nand_ale_o(ale), .nand_cle_o(cle), .nand_ce_o(ce),
    .sens_so_i(sens_so), .sens_clk_o(s_clk), .sens_dat_o(s_dat), .sens_edge_o(s_edge)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 7'(idx << 2); wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input int idx, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = 7'(idx << 2);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rdata", rdata, 32'h0);
    check("R1 flash strobes", {29'h0, ale, cle, ce}, 32'h0);
    check("R1 sensor pins", {29'h0, s_clk, s_dat, s_edge}, 32'h0);
    bus_read(0, d);  check("R1 word0", d, 32'h0);
    bus_read(16, d); check("R1 word16", d, 32'h0);
    bus_read(5, d);  check("R1 word5", d, 32'h0);
  endtask

  task automatic t_plain();
    logic [31:0] d;
    bus_write(3, 32'hA5A5_0001);
    bus_write(22, 32'h1357_9BDF);
    bus_write(9, 32'hFFFF_0000);
    bus_read(3, d);  check("R3 word3", d, 32'hA5A5_0001);
    bus_read(22, d); check("R3 word22", d, 32'h1357_9BDF);
    bus_read(9, d);  check("R3 word9", d, 32'hFFFF_0000);
  endtask

  task automatic t_porta();
    logic [31:0] d;
    bus_write(0, 32'hFFFF_FF70);
    check("R7 strobes after 0x70", {29'h0, ale, cle, ce}, 32'h7);
    bus_write(2, 32'h0000_FF0F);
    nand_rdy = 1'b1;
    bus_read(1, d); check("R4 din rdy=1", d, 32'h0000_FF80);
    nand_rdy = 1'b0;
    bus_read(1, d); check("R4 din rdy=0", d, 32'h0000_FF00);
    bus_read(0, d); check("R3 word0 readback", d, 32'hFFFF_FF70);
    bus_write(0, 32'h0000_0020);
    check("R7 strobes after 0x20", {29'h0, ale, cle, ce}, 32'h2);
    bus_write(0, 32'h0000_0050);
    check("R7 strobes after 0x50", {29'h0, ale, cle, ce}, 32'h5);
  endtask

  task automatic t_din_ro();
    logic [31:0] d;
    bus_write(1, 32'hFFFF_FFFF);
    bus_read(1, d);  check("R6 port A view", d, 32'h0000_0000);
    bus_read(0, d);  check("R6 word0 kept", d, 32'h0000_0050);
    bus_write(17, 32'hFFFF_FFFF);
    bus_read(17, d); check("R6 port D view", d, 32'h0);
    bus_read(16, d); check("R6 word16 kept", d, 32'h0);
    check("R6 no sensor edge", {31'h0, s_edge}, 32'h0);
  endtask

  task automatic t_portd();
    logic [31:0] d;
    bus_write(18, 32'h0000_00FF);
    bus_write(16, 32'hF000_000C);
    check("R9 no edge bit1 stays 0", {31'h0, s_edge}, 32'h0);
    sens_so = 1'b1;
    bus_read(17, d); check("R5 din so=1", d, 32'h0000_001C);
    sens_so = 1'b0;
    bus_read(17, d); check("R5 din so=0", d, 32'h0000_000C);
  endtask

  task automatic t_sensor();
    bus_write(16, 32'h0000_0012);
    check("R8 rise pulse", {29'h0, s_edge, s_clk, s_dat}, 32'h7);
    @(negedge clk);
    check("R8 pulse one cycle", {31'h0, s_edge}, 32'h0);
    bus_write(16, 32'h0000_0006);
    check("R9 no edge, pins kept", {29'h0, s_edge, s_clk, s_dat}, 32'h3);
    bus_write(16, 32'h0000_0000);
    check("R8 fall pulse", {29'h0, s_edge, s_clk, s_dat}, 32'h4);
  endtask

  task automatic t_oor();
    logic [31:0] d;
    bus_write(25, 32'h0000_1234);
    bus_read(25, d); check("R10 idx25", d, 32'h0);
    bus_read(23, d); check("R10 idx23", d, 32'h0);
    bus_read(31, d); check("R10 idx31", d, 32'h0);
  endtask

  task automatic t_rw_same();
    logic [31:0] d;
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 7'(3 << 2); wdata = 32'h0000_DEAD;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R11 old value", rdata, 32'hA5A5_0001);
    bus_read(3, d); check("R11 new value", d, 32'h0000_DEAD);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    bus_read(22, d);
    bus_write(22, 32'h0);
    repeat (3) @(negedge clk);
    check("R2 hold without read", rdata, 32'h1357_9BDF);
    @(negedge clk);
    rd_en = 1'b1; addr = 7'(9 << 2);
    #1 check("R2 not before edge", rdata, 32'h1357_9BDF);
    @(posedge clk);
    #1 check("R2 one cycle latency", rdata, 32'hFFFF_0000);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_porta();
    t_din_ro();
    t_portd();
    t_sensor();
    t_oor();
    t_rw_same();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule